// File: doc/BRIEF.md
# Performance-State Transition Sequencer

This block moves a multi-core processor from one shared frequency and voltage operating point to another. Each core presents a requested state index, and an activity mask says which cores take part. The sequencer picks the highest requested index among the active cores as its target. It maps that index to a frequency code and a voltage code with a computed table. It then walks the supply and the clock to the target, in an order that keeps the clock no faster than the present voltage supports.

Voltage moves one code per request to an external regulator. A programmable interval paces the steps, and each step waits for the regulator's acknowledge. A frequency change is a single code load to a PLL, followed by a wait for lock. The target is evaluated again after every step or relock. A changed request therefore takes over a transition that is already in flight, at the next step boundary, and the old target is not finished first.

Top module: `pst_seq`

## Requirements
- R1: State index i maps to frequency code 8+4i and voltage code 40+3i, where the defaults give 3-bit indices and 4 cores. The target is the largest core_req field (core c at bits [3c+2:3c]) among cores whose core_active bit is set. When the sequencer is idle, pll_code and vr_code equal the codes of that target.
- R2: When raising frequency, every voltage step up to the target voltage is acknowledged before pll_load is issued. At each pll_load, the acknowledged voltage is at least the voltage code of the loaded state.
- R3: When lowering frequency, the PLL is loaded and locked first. No voltage request is issued while the PLL is relocking, and no lowered voltage code falls below the code needed by the last loaded frequency.
- R4: Each vr_req carries a code exactly one step above or below the last acknowledged voltage. vr_req and vr_code hold steady until vr_ack is seen, and vr_req falls on the edge that takes the acknowledge.
- R5: Within a transition, the next vr_req rises exactly step_interval+2 clock edges after the edge that took the previous acknowledge, unless a PLL load comes between them.
- R6: A new target applied during a voltage ramp is adopted at the next step boundary. The old target's frequency is never loaded, and its voltage is never reached unless the new target needs it.
- R7: A new target applied while the PLL is relocking is acted on only after lock. pll_code stays unchanged and no pll_load is issued until pll_lock returns. pll_lock must drop by the cycle after pll_load.
- R8: With core_active all zero, the sequencer holds its last target and starts no transition. busy stays low and both codes stay unchanged.
- R9: busy is high from the first edge of a transition until its last step completes. done pulses for one cycle, with busy low, when voltage and frequency both equal the target. Neither busy nor done rises when the target is already in effect.
- R10: After reset, busy, done, vr_req and pll_load are low, pll_code is 8 and vr_code is 40, which are the codes of state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_req | input | NCORES*IW | Packed per-core requested state indices |
| core_active | input | NCORES | Per-core activity mask |
| step_interval | input | TW | Extra wait cycles before each voltage step |
| vr_req | output | 1 | Voltage step request to the regulator |
| vr_code | output | VW | Requested voltage code |
| vr_ack | input | 1 | Regulator acknowledge of the current step |
| pll_load | output | 1 | One-cycle PLL frequency load strobe |
| pll_code | output | FW | Frequency code for the PLL |
| pll_lock | input | 1 | PLL lock indication |
| busy | output | 1 | Transition in progress |
| done | output | 1 | One-cycle pulse when a transition completes |

## Verification
A change of request is seen on the next edge. A voltage request appears step_interval+1 edges later from idle, and step_interval+2 edges after each taken acknowledge. pll_load lasts one cycle, and the block waits at least one cycle after it before it samples lock. The bench drives inputs after a falling edge and samples at falling edges. It uses a cycle counter to time each request rise against the acknowledge edge it follows. Final codes are checked only once busy has dropped, and done is counted in the same falling-edge monitor. Ordering rules are checked on every load and request event against a bench regulator and PLL model.

// File: rtl/pst_pkg.sv
package pst_pkg;
  typedef enum logic [2:0] {
    PS_IDLE, PS_EVAL, PS_WAIT, PS_VREQ, PS_PLOAD, PS_PLL
  } pst_state_e;

  typedef enum logic [1:0] {
    ACT_NONE, ACT_VSTEP, ACT_FLOAD
  } pst_act_e;
endpackage

// File: rtl/pst_table.sv
module pst_table #(
  parameter int IW     = 3,
  parameter int FW     = 8,
  parameter int VW     = 8,
  parameter int F_BASE = 8,
  parameter int F_STEP = 4,
  parameter int V_BASE = 40,
  parameter int V_STEP = 3
) (
  input  logic [IW-1:0] idx,
  output logic [FW-1:0] fcode,
  output logic [VW-1:0] vcode
);
  function automatic logic [FW-1:0] f_of(input logic [IW-1:0] i);
    return FW'(F_BASE + int'(i) * F_STEP);
  endfunction

  function automatic logic [VW-1:0] v_of(input logic [IW-1:0] i);
    return VW'(V_BASE + int'(i) * V_STEP);
  endfunction

  assign fcode = f_of(idx);
  assign vcode = v_of(idx);
endmodule

// File: rtl/pst_resolve.sv
module pst_resolve #(
  parameter int NCORES = 4,
  parameter int IW     = 3
) (
  input  logic [NCORES*IW-1:0] core_req,
  input  logic [NCORES-1:0]    core_active,
  input  logic [IW-1:0]        hold_idx,
  output logic [IW-1:0]        tgt_idx,
  output logic                 any_active
);
  logic [IW-1:0] req_u [NCORES];
  logic [IW-1:0] best;

  for (genvar c = 0; c < NCORES; c++) begin : g_unpack
    assign req_u[c] = core_req[c*IW +: IW];
  end

  always_comb begin
    best = '0;
    for (int c = 0; c < NCORES; c++) begin
      if (core_active[c] && req_u[c] > best) best = req_u[c];
    end
  end

  assign any_active = |core_active;
  assign tgt_idx    = any_active ? best : hold_idx;
endmodule

// File: rtl/pst_ramp_timer.sv
module pst_ramp_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          en,
  input  logic [TW-1:0] interval,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= interval;
    else if (en && cnt != '0)  cnt <= cnt - TW'(1);
  end

  assign expired = (cnt == '0);

  // R5
  tmr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && cnt != '0) |=> (cnt == $past(cnt) - TW'(1)));
endmodule

// File: rtl/pst_seq.sv
module pst_seq
  import pst_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int IW     = 3,
  parameter int FW     = 8,
  parameter int VW     = 8,
  parameter int TW     = 8,
  parameter int F_BASE = 8,
  parameter int F_STEP = 4,
  parameter int V_BASE = 40,
  parameter int V_STEP = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCORES*IW-1:0] core_req,
  input  logic [NCORES-1:0]    core_active,
  input  logic [TW-1:0]        step_interval,
  output logic                 vr_req,
  output logic [VW-1:0]        vr_code,
  input  logic                 vr_ack,
  output logic                 pll_load,
  output logic [FW-1:0]        pll_code,
  input  logic                 pll_lock,
  output logic                 busy,
  output logic                 done
);
  localparam logic [FW-1:0] F_RST = FW'(F_BASE);
  localparam logic [VW-1:0] V_RST = VW'(V_BASE);

  pst_state_e    state;
  pst_act_e      act;
  logic          step_up;
  logic [IW-1:0] tgt_idx, tgt_q;
  logic          any_active;
  logic [FW-1:0] tf, cur_f, pll_code_q;
  logic [VW-1:0] tv, cur_v, vr_code_q, vneed_q;
  logic          deciding, tmr_load, tmr_exp;

  pst_resolve #(.NCORES(NCORES), .IW(IW)) u_res (
    .core_req(core_req), .core_active(core_active), .hold_idx(tgt_q),
    .tgt_idx(tgt_idx), .any_active(any_active));

  pst_table #(.IW(IW), .FW(FW), .VW(VW), .F_BASE(F_BASE), .F_STEP(F_STEP),
              .V_BASE(V_BASE), .V_STEP(V_STEP)) u_tab (
    .idx(tgt_idx), .fcode(tf), .vcode(tv));

  // Direction choice from the voltage and frequency already in effect
  always_comb begin
    act     = ACT_NONE;
    step_up = 1'b0;
    if (tf > cur_f) begin
      if (cur_v < tv) begin act = ACT_VSTEP; step_up = 1'b1; end
      else              act = ACT_FLOAD;
    end else if (tf < cur_f) begin
      act = ACT_FLOAD;
    end else if (cur_v < tv) begin
      act = ACT_VSTEP; step_up = 1'b1;
    end else if (cur_v > tv) begin
      act = ACT_VSTEP;
    end
  end

  assign deciding = (state == PS_IDLE) || (state == PS_EVAL);
  assign tmr_load = deciding && (act == ACT_VSTEP);

  pst_ramp_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .en(state == PS_WAIT),
    .interval(step_interval), .expired(tmr_exp));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PS_IDLE;
      tgt_q      <= '0;
      cur_f      <= F_RST;
      cur_v      <= V_RST;
      pll_code_q <= F_RST;
      vr_code_q  <= V_RST;
      vneed_q    <= V_RST;
      done       <= 1'b0;
    end else begin
      tgt_q <= tgt_idx;
      done  <= 1'b0;
      case (state)
        PS_IDLE, PS_EVAL: begin
          case (act)
            ACT_VSTEP: begin
              vr_code_q <= step_up ? cur_v + VW'(1) : cur_v - VW'(1);
              state     <= PS_WAIT;
            end
            ACT_FLOAD: begin
              pll_code_q <= tf;
              vneed_q    <= tv;
              state      <= PS_PLOAD;
            end
            default: begin
              if (state == PS_EVAL) done <= 1'b1;
              state <= PS_IDLE;
            end
          endcase
        end
        PS_WAIT:  if (tmr_exp) state <= PS_VREQ;
        PS_VREQ:  if (vr_ack) begin cur_v <= vr_code_q; state <= PS_EVAL; end
        PS_PLOAD: state <= PS_PLL;
        PS_PLL:   if (pll_lock) begin cur_f <= pll_code_q; state <= PS_EVAL; end
        default:  state <= PS_IDLE;
      endcase
    end
  end

  assign vr_req   = (state == PS_VREQ);
  assign vr_code  = vr_code_q;
  assign pll_load = (state == PS_PLOAD);
  assign pll_code = pll_code_q;
  assign busy     = (state != PS_IDLE);

  // R4
  vr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vr_req) |-> (vr_code == cur_v + VW'(1) || vr_code + VW'(1) == cur_v));
  // R4
  vr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vr_req && !vr_ack) |=> (vr_req && $stable(vr_code)));
  // R2
  f_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_load |-> (vneed_q <= cur_v));
  // R3
  v_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vr_req && vr_code < cur_v) |-> (vr_code >= vneed_q));
  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_PLL && !pll_lock) |=> ($stable(pll_code) && !pll_load));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_IDLE && !any_active) |=> !busy);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && pll_code == cur_f && vr_code == cur_v));
endmodule

// File: tb/sim_pst_seq.sv
`timescale 1ns/1ps
module sim_pst_seq;
  localparam int NC = 4;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC*IW-1:0] core_req = '0;
  logic [NC-1:0] core_active = '0;
  logic [7:0]    step_interval = '0;
  logic          vr_req, vr_ack, pll_load, pll_lock, busy, done;
  logic [7:0]    vr_code, pll_code;

  pst_seq u0 (
    .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_active(core_active),
    .step_interval(step_interval), .vr_req(vr_req), .vr_code(vr_code),
    .vr_ack(vr_ack), .pll_load(pll_load), .pll_code(pll_code),
    .pll_lock(pll_lock), .busy(busy), .done(done));

  always #5 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  int lock_delay = 3;

  function automatic int fexp(int i); return 8 + 4 * i; endfunction
  function automatic int vexp(int i); return 40 + 3 * i; endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Regulator model: one-cycle acknowledge two cycles after a request
  int ack_cnt = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin vr_ack <= 1'b0; ack_cnt <= 0; end
    else if (vr_req && !vr_ack) begin
      if (ack_cnt == 1) begin vr_ack <= 1'b1; ack_cnt <= 0; end
      else ack_cnt <= ack_cnt + 1;
    end else vr_ack <= 1'b0;
  end

  // PLL model: lock drops on load, returns after lock_delay cycles
  int lk_cnt = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin pll_lock <= 1'b1; lk_cnt <= 0; end
    else if (pll_load) begin pll_lock <= 1'b0; lk_cnt <= lock_delay; end
    else if (!pll_lock) begin
      if (lk_cnt <= 1) pll_lock <= 1'b1;
      else lk_cnt <= lk_cnt - 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // Event monitor, sampled at falling edges
  int  mon_v = 40, mon_f = 8, done_cnt = 0, loads = 0;
  int  max_f = 0, max_v = 0, ack_cyc = 0;
  bit  gap_ok = 0, prev_vr = 0, busy_seen = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (busy) busy_seen = 1;
      if (pll_load) begin
        loads++;
        if (int'(pll_code) > max_f) max_f = int'(pll_code);
        // R2: voltage already supports the loaded frequency
        chk(mon_v >= vexp((int'(pll_code) - 8) / 4), "R2 load above voltage", mon_v,
            vexp((int'(pll_code) - 8) / 4));
        // R7: never load while the PLL is relocking
        chk(pll_lock, "R7 load during relock", pll_lock, 1);
        mon_f = int'(pll_code);
        gap_ok = 0;
      end
      if (vr_req && !prev_vr) begin
        if (int'(vr_code) > max_v) max_v = int'(vr_code);
        // R4: one code step from last acknowledged voltage
        chk(int'(vr_code) == mon_v + 1 || int'(vr_code) == mon_v - 1, "R4 step size",
            int'(vr_code), mon_v);
        // R3: no voltage request while relocking, floor respected
        chk(pll_lock, "R3 voltage during relock", pll_lock, 1);
        chk(int'(vr_code) >= vexp((mon_f - 8) / 4), "R3 voltage floor", int'(vr_code),
            vexp((mon_f - 8) / 4));
        // R5: ramp pacing between consecutive steps
        if (gap_ok)
          chk(cyc - (ack_cyc + 1) == int'(step_interval) + 2, "R5 step gap",
              cyc - (ack_cyc + 1), int'(step_interval) + 2);
      end
      if (vr_req && vr_ack) begin
        mon_v = int'(vr_code);
        ack_cyc = cyc;
        gap_ok = 1;
      end
      if (!busy) gap_ok = 0;
      prev_vr = vr_req;
    end
  end

  task automatic settle();
    int n = 0;
    repeat (2) @(negedge clk);
    while (busy && n < 3000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  initial begin
    int prev = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!busy && !done, "R10 busy/done after reset", busy, 0);
    chk(!vr_req && !pll_load, "R10 strobes after reset", vr_req, 0);
    chk(pll_code == 8, "R10 pll_code reset", int'(pll_code), 8);
    chk(vr_code == 40, "R10 vr_code reset", int'(vr_code), 40);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 / R9 sweep over masks and request patterns
    for (int p = 0; p < 5; p++) begin
      for (int m = 1; m < 16; m++) begin
        int exp = 0, dc0;
        step_interval = 8'(p % 3);
        for (int c = 0; c < NC; c++) begin
          int r = (p * 3 + c * 5 + m) % 8;
          core_req[c*IW +: IW] = IW'(r);
          if (m[c] && r > exp) exp = r;
        end
        core_active = NC'(m);
        dc0 = done_cnt;
        busy_seen = 0;
        settle();
        chk(int'(pll_code) == fexp(exp), "R1 frequency code", int'(pll_code), fexp(exp));
        chk(int'(vr_code) == vexp(exp), "R1 voltage code", int'(vr_code), vexp(exp));
        chk(done_cnt - dc0 == (exp != prev ? 1 : 0), "R9 done count", done_cnt - dc0,
            exp != prev ? 1 : 0);
        chk(busy_seen == (exp != prev), "R9 busy only on change", busy_seen, exp != prev);
        chk(!busy, "R9 busy low at end", busy, 0);
        prev = exp;
      end
    end

    // R8: no active core, no transition
    core_req = '1;
    core_active = '0;
    busy_seen = 0;
    repeat (30) @(negedge clk);
    chk(!busy_seen, "R8 busy with no active core", busy_seen, 0);
    chk(int'(pll_code) == fexp(prev), "R8 frequency held", int'(pll_code), fexp(prev));
    chk(int'(vr_code) == vexp(prev), "R8 voltage held", int'(vr_code), vexp(prev));

    // Go to state 0 as a base
    core_req = '0;
    core_active = 4'b0001;
    settle();

    // R6: preempt an upward ramp toward 7 with target 2
    step_interval = 8'd3;
    max_f = 0; max_v = 0;
    core_req[0 +: IW] = 3'd7;
    repeat (100) @(negedge clk);
    core_req[0 +: IW] = 3'd2;
    settle();
    chk(int'(pll_code) == fexp(2), "R6 frequency after preempt", int'(pll_code), fexp(2));
    chk(int'(vr_code) == vexp(2), "R6 voltage after preempt", int'(vr_code), vexp(2));
    chk(max_f <= fexp(2), "R6 old frequency never loaded", max_f, fexp(2));
    chk(max_v < vexp(7), "R6 old voltage never reached", max_v, vexp(7));

    // R7: preempt a downward relock
    step_interval = 8'd0;
    core_req[0 +: IW] = 3'd7;
    settle();
    lock_delay = 30;
    loads = 0;
    core_req[0 +: IW] = 3'd0;
    repeat (8) @(negedge clk);
    chk(!pll_lock, "R7 PLL relocking", pll_lock, 0);
    core_req[0 +: IW] = 3'd7;
    repeat (10) @(negedge clk);
    chk(loads == 1 && int'(pll_code) == fexp(0), "R7 code held during relock",
        int'(pll_code), fexp(0));
    settle();
    chk(loads == 2, "R7 reload after lock", loads, 2);
    chk(int'(pll_code) == fexp(7) && int'(vr_code) == vexp(7), "R7 final state",
        int'(pll_code), fexp(7));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule